// File: doc/BRIEF.md
# Encoder-Tuned Square-Wave Clock Source

This block derives a square-wave system clock for a small processor board from one fixed reference clock. The output frequency is taken from a ladder of 1-2-5 steps per decade. By default the ladder runs from 1 Hz to 1 MHz against a 16 MHz reference. The output high time always equals its low time. A detented quadrature rotary knob moves the selection up or down the ladder one step per detent. The current step number is brought out so that an external display can show it.

Each step holds a half-period count, which is the reference frequency divided by twice the step frequency. A counter running on the reference clock toggles the output each time that count is reached. A step change is loaded only when the output toggles. A phase that is already in progress therefore always finishes at its original length.

Top module: `clkgen_top`

## Requirements
- R1: A synchronous reset drives the output clock low and selects step 0, the lowest frequency.
- R2: At step k the frequency is m·10^(k div 3) Hz, with m = 1, 2, 5 for k mod 3 = 0, 1, 2. Each output level lasts REF_HZ / (2·frequency) reference cycles.
- R3: The high time and the low time of every output period are equal.
- R4: One full clockwise detent raises the step by one. Clockwise means the knob pins {A,B} pass through 11, 01, 00, 10 and back to 11.
- R5: One full counter-clockwise detent lowers the step by one. Counter-clockwise means {A,B} pass through 11, 10, 00, 01 and back to 11.
- R6: The step saturates. A clockwise detent at the top step (3·DECADES) and a counter-clockwise detent at step 0 leave it unchanged.
- R7: A partial movement that returns to the rest state 11 without completing four quarter transitions in one direction leaves the step unchanged.
- R8: A new step's half-period count takes effect only at the next output edge, so the level in progress keeps its old length.
- R9: The knob pins pass through a two-stage synchronizer before they are decoded. The step output moves by at most one per reference cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| encA | input | 1 | Knob quadrature pin A, asynchronous |
| encB | input | 1 | Knob quadrature pin B, asynchronous |
| clkOut | output | 1 | Generated 50 percent duty clock |
| stepIdx | output | STEP_W | Currently selected ladder step |

## Verification
The bench builds the block with REF_HZ = 2000 and DECADES = 3. The ladder is then 1 Hz to 1 kHz, and the half periods run from 1000 cycles down to a single cycle. At these settings the slowest step, the fastest step (output toggling every reference cycle) and both saturation ends can each be measured in a few thousand cycles. The mid-phase step change of R8 is measured on the 1000-cycle phase, where an early reload would show up clearly.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  // Strobes from the knob decoder to the divider datapath
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } stepCmd_t;

  // Frequency in Hz of ladder step k: mantissa 1/2/5 times a power of ten
  function automatic longint unsigned stepHz(input int k);
    longint unsigned p;
    longint unsigned m;
    p = 1;
    for (int i = 0; i < k / 3; i++) p = p * 10;
    case (k % 3)
      0:       m = 1;
      1:       m = 2;
      default: m = 5;
    endcase
    return m * p;
  endfunction

endpackage

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     encA,
  input  logic     encB,
  output stepCmd_t cmd
);

  localparam logic [1:0] REST = 2'b11;

  logic [1:0] syncA, syncB;
  logic [1:0] prevState;
  logic [1:0] currState;
  logic signed [3:0] quarterAcc;
  logic signed [3:0] accNext;
  logic signed [3:0] delta;
  logic [1:0] posCurr, posPrev, posDiff;
  stepCmd_t cmdNext;

  // Two-stage synchronizers (R9)
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 2'b11;
      syncB <= 2'b11;
    end else begin
      syncA <= {syncA[0], encA};
      syncB <= {syncB[0], encB};
    end
  end

  assign currState = {syncA[1], syncB[1]};

  // Position along the clockwise cycle 11 -> 01 -> 00 -> 10
  function automatic logic [1:0] cyclePos(input logic [1:0] s);
    case (s)
      2'b11:   return 2'd0;
      2'b01:   return 2'd1;
      2'b00:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  always_comb begin
    posCurr = cyclePos(currState);
    posPrev = cyclePos(prevState);
    posDiff = posCurr - posPrev;
    case (posDiff)
      2'd1:    delta = 4'sd1;
      2'd3:    delta = -4'sd1;
      default: delta = 4'sd0;   // no move, or a skipped state
    endcase
    accNext = quarterAcc + delta;
    cmdNext = '0;
    if (currState == REST) begin
      cmdNext.stepUp   = (accNext == 4'sd4);
      cmdNext.stepDown = (accNext == -4'sd4);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevState  <= REST;
      quarterAcc <= '0;
      cmd        <= '0;
    end else begin
      prevState  <= currState;
      quarterAcc <= (currState == REST) ? 4'sd0 : accNext;
      cmd        <= cmdNext;
    end
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd.stepUp, cmd.stepDown}));

  // R7
  acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (quarterAcc <= 4'sd4) && (quarterAcc >= -4'sd4));

endmodule

// File: rtl/clkgen_div.sv
module clkgen_div
  import clkgen_pkg::*;
#(
  parameter int REF_HZ  = 16_000_000,
  parameter int DECADES = 6
) (
  input  logic     clk,
  input  logic     rst,
  input  stepCmd_t cmd,
  output logic     clkOut,
  output logic [$clog2(3*DECADES+1)-1:0] stepIdx
);

  localparam int NUM_STEPS = 3 * DECADES + 1;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int HALF_MAX  = REF_HZ / 2;
  localparam int CNT_W     = $clog2(HALF_MAX + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  logic [CNT_W-1:0] halfTable [NUM_STEPS];
  logic [CNT_W-1:0] activeHalf;
  logic [CNT_W-1:0] cnt;
  logic             phaseEnd;

  // Half-period count per step, computed at elaboration (R2)
  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_table
    localparam longint unsigned HALF_VAL = (longint'(REF_HZ) / 2) / stepHz(g);
    assign halfTable[g] = HALF_VAL[CNT_W-1:0];
  end

  // Saturating step register (R4, R5, R6)
  always_ff @(posedge clk) begin
    if (rst) begin
      stepIdx <= '0;
    end else if (cmd.stepUp && stepIdx != LAST_STEP) begin
      stepIdx <= stepIdx + 1'b1;
    end else if (cmd.stepDown && stepIdx != '0) begin
      stepIdx <= stepIdx - 1'b1;
    end
  end

  assign phaseEnd = (cnt == activeHalf - 1'b1);

  // Divider: reload the half count only on an output edge (R3, R8)
  always_ff @(posedge clk) begin
    if (rst) begin
      clkOut     <= 1'b0;
      cnt        <= '0;
      activeHalf <= halfTable[0];
    end else if (phaseEnd) begin
      clkOut     <= ~clkOut;
      cnt        <= '0;
      activeHalf <= halfTable[stepIdx];
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    stepIdx <= LAST_STEP);

  // R9
  step_delta_chk: assert property (@(posedge clk) disable iff (rst)
    (stepIdx == $past(stepIdx)) || (stepIdx == $past(stepIdx) + 1'b1) ||
    (stepIdx == $past(stepIdx) - 1'b1));

  // R8
  reload_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (activeHalf != $past(activeHalf)) |-> (clkOut != $past(clkOut)));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < activeHalf);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!clkOut && stepIdx == '0));

endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
  import clkgen_pkg::*;
#(
  parameter int REF_HZ  = 16_000_000,
  parameter int DECADES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic encA,
  input  logic encB,
  output logic clkOut,
  output logic [$clog2(3*DECADES+1)-1:0] stepIdx
);

  stepCmd_t stepCmd;

  clkgen_ctrl i_ctrl (
    .clk  (clk),
    .rst  (rst),
    .encA (encA),
    .encB (encB),
    .cmd  (stepCmd)
  );

  clkgen_div #(
    .REF_HZ  (REF_HZ),
    .DECADES (DECADES)
  ) i_div (
    .clk     (clk),
    .rst     (rst),
    .cmd     (stepCmd),
    .clkOut  (clkOut),
    .stepIdx (stepIdx)
  );

endmodule

// File: tb/test_clkgen_top.sv
module test_clkgen_top;

  localparam int REF_HZ    = 2000;
  localparam int DECADES   = 3;
  localparam int NUM_STEPS = 3 * DECADES + 1;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic encA = 1'b1;
  logic encB = 1'b1;
  logic clkOut;
  logic [STEP_W-1:0] stepIdx;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;   // 50 MHz

  clkgen_top #(.REF_HZ(REF_HZ), .DECADES(DECADES)) i_clkgen_top (
    .clk(clk), .rst(rst), .encA(encA), .encB(encB),
    .clkOut(clkOut), .stepIdx(stepIdx)
  );

  function automatic int expHalf(input int k);
    int f;
    f = (k % 3 == 0) ? 1 : (k % 3 == 1) ? 2 : 5;
    for (int i = 0; i < k / 3; i++) f = f * 10;
    return REF_HZ / 2 / f;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setPins(input logic [1:0] ab);
    @(negedge clk);
    encA = ab[1];
    encB = ab[0];
    repeat (2) @(negedge clk);
  endtask

  task automatic turn(input bit cw);
    if (cw) begin
      setPins(2'b01); setPins(2'b00); setPins(2'b10); setPins(2'b11);
    end else begin
      setPins(2'b10); setPins(2'b00); setPins(2'b01); setPins(2'b11);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int lo);
    do @(negedge clk); while (clkOut !== 1'b0);
    do @(negedge clk); while (clkOut !== 1'b1);
    hi = 0;
    while (clkOut === 1'b1) begin hi++; @(negedge clk); end
    lo = 0;
    while (clkOut === 1'b0) begin lo++; @(negedge clk); end
  endtask

  task automatic checkPeriod(input int k);
    int hi, lo;
    measure(hi, lo);
    check(hi == expHalf(k), "R2 high time", hi, expHalf(k));
    check(lo == hi, "R3 low equals high", lo, hi);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int model;
    int lowCnt, hiCnt;
    void'($urandom(32'd2024));

    repeat (4) @(negedge clk);
    check(clkOut == 1'b0, "R1 clkOut in reset", int'(clkOut), 0);
    check(stepIdx == 0, "R1 step in reset", int'(stepIdx), 0);

    // R8: first low phase (step 0) must keep its length despite a mid-phase CW detent
    rst = 1'b0;
    lowCnt = 0;
    fork
      begin
        for (int n = 0; n < 5000 && clkOut === 1'b0; n++) begin
          lowCnt++;
          @(negedge clk);
        end
      end
      begin
        repeat (100) @(negedge clk);
        turn(1'b1);
      end
    join
    check(lowCnt == expHalf(0), "R8 old phase length kept", lowCnt, expHalf(0));
    check(stepIdx == 1, "R4 step after CW", int'(stepIdx), 1);
    hiCnt = 0;
    while (clkOut === 1'b1) begin hiCnt++; @(negedge clk); end
    check(hiCnt == expHalf(1), "R8 new count at next edge", hiCnt, expHalf(1));
    checkPeriod(1);

    turn(1'b0);
    check(stepIdx == 0, "R5 step after CCW", int'(stepIdx), 0);
    checkPeriod(0);
    turn(1'b0);
    check(stepIdx == 0, "R6 floor saturation", int'(stepIdx), 0);

    // R7: partial move and return
    setPins(2'b01); setPins(2'b00); setPins(2'b01); setPins(2'b11);
    repeat (6) @(negedge clk);
    check(stepIdx == 0, "R7 partial CW ignored", int'(stepIdx), 0);
    setPins(2'b10); setPins(2'b11);
    repeat (6) @(negedge clk);
    check(stepIdx == 0, "R7 partial CCW ignored", int'(stepIdx), 0);

    for (int k = 1; k < NUM_STEPS; k++) begin
      turn(1'b1);
      check(stepIdx == k, "R4 climb", int'(stepIdx), k);
    end
    checkPeriod(NUM_STEPS - 1);
    turn(1'b1);
    check(stepIdx == NUM_STEPS - 1, "R6 top saturation", int'(stepIdx), NUM_STEPS - 1);
    checkPeriod(NUM_STEPS - 1);

    // Random walk, R4/R5/R6 with period checks (R2, R3)
    model = NUM_STEPS - 1;
    for (int it = 0; it < 24; it++) begin
      bit cw;
      cw = ($urandom % 2) == 1;
      turn(cw);
      if (cw && model < NUM_STEPS - 1) model++;
      else if (!cw && model > 0) model--;
      check(stepIdx == model, "R9 R4 R5 random walk step", int'(stepIdx), model);
      checkPeriod(model);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule